// File: doc/BRIEF.md
# Countdown Event Timer

A register-programmed down-counter that flags an event and can raise a level interrupt each time its count runs out. Software writes a reload value, a live count and a control word, then starts the counter. A prescaler slows the count rate to once every N+1 clock cycles. In one-shot mode the counter stops at zero after a single event. In periodic mode it reloads itself on every expiry.

The reload value and the live count are separate registers. Software can therefore make the first timeout differ from the repeat period: it writes the count with the first delay and the reload register with the period. The event flag is sticky and is cleared by writing a one to it. The interrupt pin shows the flag only while the interrupt enable bit is set.

Top module: `evt_timer`

## Requirements
- R1: During and after reset every register reads zero and `irq` is low.
- R2: `addr` selects a word register: 0 reload value, 1 live count, 2 control, 3 status (byte offsets 0x0, 0x4, 0x8, 0xC). A write stores `wr_data` at the edge, and `rd_data` returns the selected register in the same cycle. In control, bit 0 is run, bit 1 is periodic, bit 2 is interrupt enable and bits 15:8 are the prescale value P. All other control bits read as zero.
- R3: While run is set, the live count decreases by one every P+1 clocks. The first decrement comes P+1 cycles after the edge that sets run.
- R4: When a decrement takes the count from 1 to 0, the status flag (bit 0) sets at that same edge. In one-shot mode (periodic = 0) the count then stays at 0 and no further event occurs.
- R5: In periodic mode the expiry that would reach 0 instead loads the reload value, so events repeat every reload × (P+1) cycles.
- R6: The first expiry is timed by the value written to the live count, independently of the reload register.
- R7: A write to the live count wins over a decrement due in the same cycle. The written value appears unchanged.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it set. If an expiry and a clear land in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when the flag is set and interrupt enable is set. Clearing the enable masks `irq` without clearing the flag.
- R10: Writing 0 to control stops the counter. The count then holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register selected by addr |
| addr | input | 2 | Word register index |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the register selected by addr |
| irq | output | 1 | Level interrupt, flag gated by enable |

## Verification
The checker watches several properties on every cycle. A stopped counter holds its count. A zero count stays at zero. A write to the count always wins over a decrement, and the value written is the value that appears. A running, unwritten count steps down by exactly one per prescaler tick, and a periodic expiry reloads the reload value. The flag stays set until it is cleared, and the interrupt never shows while it is masked. Some behaviour can only be shown by the bench's scenarios: the exact spacing of decrements for a given prescale value, a first timeout that differs from the later period, the set-wins-over-clear collision, and control readback with the unused bits dropped.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        IDX_RELOAD = 2'd0,
        IDX_COUNT  = 2'd1,
        IDX_CTRL   = 2'd2,
        IDX_STATUS = 2'd3
    } reg_idx_e;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_PER_BIT   = 1;
    localparam int CTRL_IEN_BIT   = 2;
    localparam int CTRL_PRESC_LSB = 8;
    localparam int STAT_FLAG_BIT  = 0;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               expire,
    output logic [DATA_W-1:0]  reload_q,
    output logic               run,
    output logic               periodic,
    output logic               irq_en,
    output logic [PRESC_W-1:0] presc,
    output logic               flag,
    output logic               flag_clr
);

    typedef struct packed {
        logic [DATA_W-1:0]  reload;
        logic               run;
        logic               per;
        logic               ien;
        logic [PRESC_W-1:0] presc;
        logic               flag;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        flag_clr = wr_en && (addr == IDX_STATUS) && wr_data[STAT_FLAG_BIT];
        if (wr_en && addr == IDX_RELOAD) begin
            st_d.reload = wr_data;
        end
        if (wr_en && addr == IDX_CTRL) begin
            st_d.run   = wr_data[CTRL_RUN_BIT];
            st_d.per   = wr_data[CTRL_PER_BIT];
            st_d.ien   = wr_data[CTRL_IEN_BIT];
            st_d.presc = wr_data[CTRL_PRESC_LSB +: PRESC_W];
        end
        st_d.flag = (st_q.flag && !flag_clr) || expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_q = st_q.reload;
    assign run      = st_q.run;
    assign periodic = st_q.per;
    assign irq_en   = st_q.ien;
    assign presc    = st_q.presc;
    assign flag     = st_q.flag;

endmodule

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);

    logic [PRESC_W-1:0] div_d, div_q;

    always_comb begin
        tick  = run && (div_q >= presc);
        div_d = div_q + 1'b1;
        if (!run || tick) begin
            div_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              periodic,
    input  logic [DATA_W-1:0] reload,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] cnt_wdata,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] cnt_d;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (tick && cnt_q != '0) begin
            if (cnt_q == ONE) begin
                expire = 1'b1;
                cnt_d  = periodic ? reload : '0;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic [DATA_W-1:0]  reload_q;
    logic [DATA_W-1:0]  cnt_q;
    logic               run, periodic, irq_en, flag, flag_clr;
    logic [PRESC_W-1:0] presc;
    logic               tick, expire, cnt_wr;

    assign cnt_wr = wr_en && (addr == IDX_COUNT);

    evt_timer_regs #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .expire   (expire),
        .reload_q (reload_q),
        .run      (run),
        .periodic (periodic),
        .irq_en   (irq_en),
        .presc    (presc),
        .flag     (flag),
        .flag_clr (flag_clr)
    );

    evt_timer_presc #(.PRESC_W(PRESC_W)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .presc (presc),
        .tick  (tick)
    );

    evt_timer_core #(.DATA_W(DATA_W)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .periodic  (periodic),
        .reload    (reload_q),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data),
        .cnt_q     (cnt_q),
        .expire    (expire)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            IDX_RELOAD: rd_data = reload_q;
            IDX_COUNT:  rd_data = cnt_q;
            IDX_CTRL: begin
                rd_data[CTRL_RUN_BIT]              = run;
                rd_data[CTRL_PER_BIT]              = periodic;
                rd_data[CTRL_IEN_BIT]              = irq_en;
                rd_data[CTRL_PRESC_LSB +: PRESC_W] = presc;
            end
            default:    rd_data[STAT_FLAG_BIT] = flag;
        endcase
    end

    assign irq = flag && irq_en;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              tick,
    input logic              periodic,
    input logic              cnt_wr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] reload_q,
    input logic              flag,
    input logic              flag_clr,
    input logic              irq_en,
    input logic              irq
);

    assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wr_data)));

    assert_zero_rests_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !cnt_wr) |=> (cnt_q == '0));

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q > DATA_W'(1) && !cnt_wr) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && periodic && cnt_q == DATA_W'(1) && !cnt_wr) |=> (cnt_q == $past(reload_q)));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

endmodule

bind evt_timer evt_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .periodic (periodic),
    .cnt_wr   (cnt_wr),
    .wr_data  (wr_data),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .flag     (flag),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .irq      (irq)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;

    localparam int DATA_W = 32;
    localparam int NVEC   = 53;

    // op: 0 write, 1 read compare, 2 idle data cycles, 3 irq compare
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_ID = 2'd2;
    localparam logic [1:0] OP_IQ = 2'd3;

    // {op, addr, req, data, expected}
    localparam logic [71:0] VEC [NVEC] = '{
        {OP_WR, 2'd0, 4'd2,  32'd5,          32'd0},          // R2 reload write
        {OP_RD, 2'd0, 4'd2,  32'd0,          32'd5},          // R2
        {OP_WR, 2'd1, 4'd6,  32'd3,          32'd0},          // R6 first delay
        {OP_RD, 2'd1, 4'd6,  32'd0,          32'd3},          // R6
        {OP_WR, 2'd2, 4'd2,  32'hABCD_0306,  32'd0},          // R2 control
        {OP_RD, 2'd2, 4'd2,  32'd0,          32'h0000_0306},  // R2 unused bits dropped
        {OP_RD, 2'd1, 4'd10, 32'd0,          32'd3},          // R10 not running
        {OP_WR, 2'd2, 4'd5,  32'h0000_0007,  32'd0},          // R5 start periodic, P=0
        {OP_RD, 2'd1, 4'd5,  32'd0,          32'd3},          // R3
        {OP_RD, 2'd1, 4'd5,  32'd0,          32'd2},          // R3
        {OP_RD, 2'd3, 4'd6,  32'd0,          32'd0},          // R6
        {OP_RD, 2'd3, 4'd6,  32'd0,          32'd1},          // R6 first expiry after 3
        {OP_IQ, 2'd0, 4'd9,  32'd0,          32'd1},          // R9
        {OP_RD, 2'd1, 4'd5,  32'd0,          32'd3},          // R5 reloaded 5
        {OP_WR, 2'd3, 4'd8,  32'd0,          32'd0},          // R8 write 0
        {OP_RD, 2'd3, 4'd8,  32'd0,          32'd1},          // R8 still set
        {OP_WR, 2'd3, 4'd8,  32'd1,          32'd0},          // R8 clear
        {OP_RD, 2'd3, 4'd8,  32'd0,          32'd0},          // R8
        {OP_WR, 2'd2, 4'd10, 32'd0,          32'd0},          // R10 stop
        {OP_RD, 2'd1, 4'd10, 32'd0,          32'd2},          // R10
        {OP_ID, 2'd0, 4'd10, 32'd5,          32'd0},
        {OP_RD, 2'd1, 4'd10, 32'd0,          32'd2},          // R10 held
        {OP_WR, 2'd1, 4'd3,  32'd4,          32'd0},          // R3
        {OP_WR, 2'd2, 4'd3,  32'h0000_0201,  32'd0},          // R3 one-shot P=2
        {OP_RD, 2'd1, 4'd3,  32'd0,          32'd4},          // R3
        {OP_RD, 2'd1, 4'd3,  32'd0,          32'd4},          // R3
        {OP_RD, 2'd1, 4'd3,  32'd0,          32'd4},          // R3
        {OP_RD, 2'd1, 4'd3,  32'd0,          32'd3},          // R3 third cycle
        {OP_ID, 2'd0, 4'd3,  32'd7,          32'd0},
        {OP_RD, 2'd1, 4'd3,  32'd0,          32'd1},          // R3
        {OP_RD, 2'd3, 4'd4,  32'd0,          32'd1},          // R4 one-shot event
        {OP_IQ, 2'd0, 4'd9,  32'd0,          32'd0},          // R9 masked
        {OP_RD, 2'd1, 4'd4,  32'd0,          32'd0},          // R4
        {OP_ID, 2'd0, 4'd4,  32'd10,         32'd0},
        {OP_RD, 2'd1, 4'd4,  32'd0,          32'd0},          // R4 stays 0
        {OP_RD, 2'd3, 4'd9,  32'd0,          32'd1},          // R9 flag kept
        {OP_WR, 2'd2, 4'd9,  32'h0000_0204,  32'd0},          // R9 enable irq
        {OP_IQ, 2'd0, 4'd9,  32'd0,          32'd1},          // R9
        {OP_WR, 2'd3, 4'd9,  32'd1,          32'd0},          // R9 clear
        {OP_IQ, 2'd0, 4'd9,  32'd0,          32'd0},          // R9
        {OP_RD, 2'd3, 4'd8,  32'd0,          32'd0},          // R8
        {OP_WR, 2'd2, 4'd7,  32'h0000_0001,  32'd0},          // R7 run, P=0
        {OP_WR, 2'd1, 4'd7,  32'd5,          32'd0},          // R7
        {OP_WR, 2'd1, 4'd7,  32'd9,          32'd0},          // R7 write vs decrement
        {OP_RD, 2'd1, 4'd7,  32'd0,          32'd9},          // R7
        {OP_RD, 2'd1, 4'd7,  32'd0,          32'd8},          // R7
        {OP_WR, 2'd2, 4'd8,  32'd0,          32'd0},          // R8 setup
        {OP_WR, 2'd3, 4'd8,  32'd1,          32'd0},
        {OP_WR, 2'd1, 4'd8,  32'd1,          32'd0},
        {OP_WR, 2'd2, 4'd8,  32'h0000_0001,  32'd0},
        {OP_WR, 2'd3, 4'd8,  32'd1,          32'd0},          // R8 clear at expiry edge
        {OP_RD, 2'd3, 4'd8,  32'd0,          32'd1},          // R8 set wins
        {OP_RD, 2'd1, 4'd4,  32'd0,          32'd0}           // R4
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    evt_timer #(.DATA_W(DATA_W), .PRESC_W(8)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic check(input int req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_chk(input int req, input logic [1:0] a, input logic [DATA_W-1:0] exp);
        wr_en = 1'b0;
        addr  = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            read_chk(1, 2'(i), '0);
        end
        check(1, DATA_W'(irq), '0);
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]        op;
            logic [1:0]        a;
            int                rq;
            logic [DATA_W-1:0] d, e;
            op = VEC[v][71:70];
            a  = VEC[v][69:68];
            rq = int'(VEC[v][67:64]);
            d  = VEC[v][63:32];
            e  = VEC[v][31:0];
            case (op)
                OP_WR: begin
                    wr_en = 1'b1; addr = a; wr_data = d;
                end
                OP_RD: read_chk(rq, a, e);
                OP_IQ: begin
                    wr_en = 1'b0;
                    #1;
                    check(rq, DATA_W'(irq), e);
                end
                default: begin
                    wr_en = 1'b0;
                    repeat (int'(d) - 1) @(negedge clk);
                end
            endcase
            @(negedge clk);
        end

        // R1 reset while running periodic with state loaded
        wr_en = 1'b1; addr = 2'd2; wr_data = 32'h0000_0007;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 4; i++) begin
            read_chk(1, 2'(i), '0);
        end
        check(1, DATA_W'(irq), '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule